// File: doc/BRIEF.md
# Banked Memory Composer (6144 x 12)

This block presents one logical memory of 6144 words by 12 bits, assembled from five smaller synchronous RAM banks of two shapes. Three banks of 2048 words by 8 bits hold the low byte of every word. Two banks of 4096 words by 4 bits hold the high nibble. Each group has its own address decoder. The low group decodes address bits [12:11] into one of three bank enables. The high group decodes address bit [12] into one of two bank enables, and the second high bank only ever sees its lower half. An address at or above 6144 enables no bank at all.

Each bank drives its read data only while it was enabled, in the same way as a bus with tri-state outputs. The composer models this by keeping the enables of the last accepted read for one cycle. It then ORs together only those bank outputs, which matches the one-cycle read latency of the banks. When no bank was enabled, the word read back is zero.

Requests enter on a valid/ready channel, and read results leave on a second valid/ready channel. A write is accepted in one cycle and returns nothing. A read returns exactly one response, which appears in the cycle after it is accepted. Only one response can be outstanding at a time. The request channel is therefore ready exactly when the response register is empty, or when it is being drained in the same cycle. While the consumer holds the response, the response data and valid stay unchanged.

Top module: `mc_memory_composer`

## Requirements
- R1: A word written at any address from 0 to 6143 reads back later as the same 12-bit value.
- R2: A read accepted at a clock edge (req_valid and req_ready both high) raises rsp_valid after that edge, with its data.
- R3: Bits [7:0] of a word live in low bank addr[12:11] (0, 1 or 2). Bits [11:8] live in high bank addr[12]. Words on either side of the boundaries 2047/2048 and 4095/4096 stay independent.
- R4: A write to an address of 6144 or more enables no bank and changes no stored word.
- R5: A read of an address of 6144 or more returns a response whose data is zero.
- R6: While rsp_valid is high and rsp_ready is low, req_ready is low, and rsp_valid and rsp_rdata hold their values.
- R7: A write produces no response. After an accepted write, rsp_valid is low.
- R8: After reset, rsp_valid is low and req_ready is high.
- R9: For every request, at most one low bank and at most one high bank are enabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted at this edge if valid |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 13 | Word address |
| req_wdata | input | 12 | Write data |
| rsp_valid | output | 1 | Read data present |
| rsp_ready | input | 1 | Consumer takes the read data |
| rsp_rdata | output | 12 | Read data |

## Verification
The checker watches the decode on every cycle. It checks that each bank group has at most one enable active, and that an address past the top of the memory enables nothing. On the handshake it checks that each accepted read yields a response on the next cycle, that each accepted write leaves no response, and that a stalled response holds still. It also checks that out-of-range reads return zero. Whether the stored data is correct can only be shown by the bench scenarios. These write values across all five banks and across the 2047/2048 and 4095/4096 seams, read them back with varying consumer back-pressure, and confirm that writes past the top leave every stored word as it was.

// File: rtl/mc_pkg.sv
package mc_pkg;
  // default geometry of the composed memory
  localparam int unsigned LO_W_D       = 8;
  localparam int unsigned LO_DEPTH_D   = 2048;
  localparam int unsigned LO_BANKS_D   = 3;
  localparam int unsigned HI_W_D       = 4;
  localparam int unsigned HI_DEPTH_D   = 4096;
  localparam int unsigned HI_BANKS_D   = 2;
  localparam int unsigned TOTAL_WORDS_D = 6144;
  localparam int unsigned ADDR_W_D     = 13;

  typedef enum logic {
    OP_READ  = 1'b0,
    OP_WRITE = 1'b1
  } mc_op_e;
endpackage

// File: rtl/mc_bank.sv
module mc_bank #(
  parameter int unsigned W     = 8,
  parameter int unsigned DEPTH = 2048,
  localparam int unsigned AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [W-1:0]  din,
  output logic [W-1:0]  dout
);
  logic [W-1:0] cells [DEPTH];

  always_ff @(posedge clk) begin
    if (en && we) cells[addr] <= din;
  end

  // read register updates only on an enabled read, so it holds otherwise
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        dout <= '0;
    else if (en && !we) dout <= cells[addr];
  end
endmodule

// File: rtl/mc_bank_decode.sv
module mc_bank_decode #(
  parameter int unsigned ADDR_W      = 13,
  parameter int unsigned BANK_AW     = 11,
  parameter int unsigned BANKS       = 3,
  parameter int unsigned TOTAL_WORDS = 6144,
  localparam int unsigned IDX_W      = ADDR_W - BANK_AW
) (
  input  logic              go,
  input  logic [ADDR_W-1:0] addr,
  output logic [BANKS-1:0]  en
);
  logic [IDX_W-1:0] idx;
  logic             in_range;

  assign idx      = addr[ADDR_W-1:BANK_AW];
  assign in_range = (addr < ADDR_W'(TOTAL_WORDS));

  for (genvar b = 0; b < BANKS; b++) begin : g_sel
    assign en[b] = go && in_range && (idx == IDX_W'(b));
  end
endmodule

// File: rtl/mc_read_select.sv
module mc_read_select #(
  parameter int unsigned W     = 8,
  parameter int unsigned BANKS = 3
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       capture,
  input  logic [BANKS-1:0]           en,
  input  logic [BANKS-1:0][W-1:0]    bank_dout,
  output logic [W-1:0]               data
);
  logic [BANKS-1:0] sel_q;

  // remember which bank drove the last accepted read
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       sel_q <= '0;
    else if (capture) sel_q <= en;
  end

  // wired-OR of the enabled outputs; disabled banks float to zero
  always_comb begin
    data = '0;
    for (int b = 0; b < BANKS; b++) begin
      data = data | (bank_dout[b] & {W{sel_q[b]}});
    end
  end
endmodule

// File: rtl/mc_memory_composer.sv
module mc_memory_composer
  import mc_pkg::*;
#(
  parameter int unsigned LO_W        = LO_W_D,
  parameter int unsigned LO_DEPTH    = LO_DEPTH_D,
  parameter int unsigned LO_BANKS    = LO_BANKS_D,
  parameter int unsigned HI_W        = HI_W_D,
  parameter int unsigned HI_DEPTH    = HI_DEPTH_D,
  parameter int unsigned HI_BANKS    = HI_BANKS_D,
  parameter int unsigned TOTAL_WORDS = TOTAL_WORDS_D,
  parameter int unsigned ADDR_W      = ADDR_W_D,
  localparam int unsigned DATA_W     = LO_W + HI_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [DATA_W-1:0] rsp_rdata
);
  localparam int unsigned LO_AW = $clog2(LO_DEPTH);
  localparam int unsigned HI_AW = $clog2(HI_DEPTH);

  logic                         fire;
  logic                         rd_fire;
  logic [LO_BANKS-1:0]          lo_en;
  logic [HI_BANKS-1:0]          hi_en;
  logic [LO_BANKS-1:0][LO_W-1:0] lo_dout;
  logic [HI_BANKS-1:0][HI_W-1:0] hi_dout;
  logic [LO_W-1:0]              lo_data;
  logic [HI_W-1:0]              hi_data;

  assign req_ready = !rsp_valid || rsp_ready;
  assign fire      = req_valid && req_ready;
  assign rd_fire   = fire && (req_write == OP_READ);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       rsp_valid <= 1'b0;
    else if (rd_fire) rsp_valid <= 1'b1;
    else if (rsp_ready) rsp_valid <= 1'b0;
  end

  mc_bank_decode #(
    .ADDR_W(ADDR_W), .BANK_AW(LO_AW), .BANKS(LO_BANKS), .TOTAL_WORDS(TOTAL_WORDS)
  ) u_lo_dec (.go(fire), .addr(req_addr), .en(lo_en));

  mc_bank_decode #(
    .ADDR_W(ADDR_W), .BANK_AW(HI_AW), .BANKS(HI_BANKS), .TOTAL_WORDS(TOTAL_WORDS)
  ) u_hi_dec (.go(fire), .addr(req_addr), .en(hi_en));

  for (genvar b = 0; b < LO_BANKS; b++) begin : g_lo
    mc_bank #(.W(LO_W), .DEPTH(LO_DEPTH)) u_bank (
      .clk(clk), .rst_n(rst_n), .en(lo_en[b]), .we(req_write),
      .addr(req_addr[LO_AW-1:0]), .din(req_wdata[LO_W-1:0]), .dout(lo_dout[b])
    );
  end

  for (genvar b = 0; b < HI_BANKS; b++) begin : g_hi
    mc_bank #(.W(HI_W), .DEPTH(HI_DEPTH)) u_bank (
      .clk(clk), .rst_n(rst_n), .en(hi_en[b]), .we(req_write),
      .addr(req_addr[HI_AW-1:0]), .din(req_wdata[DATA_W-1:LO_W]), .dout(hi_dout[b])
    );
  end

  mc_read_select #(.W(LO_W), .BANKS(LO_BANKS)) u_lo_sel (
    .clk(clk), .rst_n(rst_n), .capture(rd_fire), .en(lo_en),
    .bank_dout(lo_dout), .data(lo_data)
  );

  mc_read_select #(.W(HI_W), .BANKS(HI_BANKS)) u_hi_sel (
    .clk(clk), .rst_n(rst_n), .capture(rd_fire), .en(hi_en),
    .bank_dout(hi_dout), .data(hi_data)
  );

  assign rsp_rdata = {hi_data, lo_data};
endmodule

// File: rtl/mc_composer_checker.sv
module mc_composer_checker #(
  parameter int unsigned ADDR_W      = 13,
  parameter int unsigned DATA_W      = 12,
  parameter int unsigned LO_BANKS    = 3,
  parameter int unsigned HI_BANKS    = 2,
  parameter int unsigned TOTAL_WORDS = 6144
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic              req_write,
  input logic [ADDR_W-1:0] req_addr,
  input logic              rsp_valid,
  input logic              rsp_ready,
  input logic [DATA_W-1:0] rsp_rdata,
  input logic [LO_BANKS-1:0] lo_en,
  input logic [HI_BANKS-1:0] hi_en
);
  logic acc;
  logic oob;
  assign acc = req_valid && req_ready;
  assign oob = (req_addr >= ADDR_W'(TOTAL_WORDS));

  p_single_lo_r9: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(lo_en));
  p_single_hi_r9: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(hi_en));

  p_oob_no_bank_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && oob) |-> (lo_en == '0 && hi_en == '0));

  p_read_next_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && !req_write) |=> rsp_valid);

  p_oob_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && !req_write && oob) |=> (rsp_rdata == '0));

  p_write_silent_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && req_write) |=> !rsp_valid);

  p_stall_block_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |-> !req_ready);

  p_stall_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_rdata)));
endmodule

bind mc_memory_composer mc_composer_checker #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .LO_BANKS(LO_BANKS),
  .HI_BANKS(HI_BANKS), .TOTAL_WORDS(TOTAL_WORDS)
) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .req_write(req_write), .req_addr(req_addr), .rsp_valid(rsp_valid),
  .rsp_ready(rsp_ready), .rsp_rdata(rsp_rdata), .lo_en(lo_en), .hi_en(hi_en)
);

// File: tb/test_mc_memory_composer.sv
module test_mc_memory_composer;
  localparam int WORDS = 6144;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic        req_write = 1'b0;
  logic [12:0] req_addr = '0;
  logic [11:0] req_wdata = '0;
  logic        rsp_valid;
  logic        rsp_ready = 1'b1;
  logic [11:0] rsp_rdata;

  int checks = 0;
  int errors = 0;
  bit toggle_en = 1'b0;
  bit done = 1'b0;

  logic [11:0] model   [WORDS];
  bit          written [WORDS];
  logic [11:0] exp_q [$];

  always #2.5 clk = ~clk;

  mc_memory_composer i_mc_memory_composer (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_rdata(rsp_rdata)
  );

  task automatic chk(input bit ok, input string req, input logic [11:0] act, input logic [11:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [11:0] pat(input int a, input int s);
    return 12'((a * 37 + s * 251 + 5) ^ (a >> 3));
  endfunction

  // called at a negedge, returns at a negedge
  task automatic send(input bit w, input int a, input logic [11:0] d);
    bit ok = 1'b0;
    req_valid = 1'b1; req_write = w; req_addr = a[12:0]; req_wdata = d;
    while (!ok) begin
      ok = req_ready;
      if (ok) begin
        if (w) begin
          if (a < WORDS) begin model[a] = d; written[a] = 1'b1; end
        end else begin
          exp_q.push_back((a < WORDS) ? model[a] : 12'h000);
        end
      end
      @(negedge clk);
    end
    req_valid = 1'b0;
    if (w) chk(rsp_valid == 1'b0, "R7 write left no response", {11'd0, rsp_valid}, 12'h000);
    else   chk(rsp_valid == 1'b1, "R2 response one cycle after read", {11'd0, rsp_valid}, 12'h001);
  endtask

  // scoreboard monitor: R1 R3 R5 data compare
  always @(negedge clk) begin
    if (rst_n && rsp_valid && rsp_ready) begin
      if (exp_q.size() == 0) begin
        chk(1'b0, "R7 unexpected response", rsp_rdata, 12'h000);
      end else begin
        logic [11:0] e;
        e = exp_q.pop_front();
        chk(rsp_rdata == e, "R1/R3/R5 read data", rsp_rdata, e);
      end
    end
  end

  // consumer back-pressure pattern, changed away from both edges
  int tcnt = 0;
  always @(posedge clk) begin
    #1;
    if (toggle_en) begin
      tcnt++;
      rsp_ready = ((tcnt % 3) != 0);
    end
  end

  int bnd[10] = '{0, 1, 2047, 2048, 2049, 4095, 4096, 4097, 6142, 6143};

  initial begin
    for (int i = 0; i < WORDS; i++) begin model[i] = '0; written[i] = 1'b0; end
    repeat (3) @(negedge clk);
    // R8 reset state
    chk(rsp_valid == 1'b0, "R8 rsp_valid in reset", {11'd0, rsp_valid}, 12'h000);
    chk(req_ready == 1'b1, "R8 req_ready in reset", {11'd0, req_ready}, 12'h001);
    rst_n = 1'b1;
    @(negedge clk);

    // R3 boundary words with distinct values, then read back
    for (int i = 0; i < 10; i++) send(1'b1, bnd[i], pat(bnd[i], 1));
    for (int i = 0; i < 10; i++) send(1'b0, bnd[i], 12'h000);

    // R1 sweep across all five banks
    for (int a = 3; a < WORDS; a += 53) send(1'b1, a, pat(a, 2));
    for (int a = 3; a < WORDS; a += 53) send(1'b0, a, 12'h000);

    // R4 writes past the top, then re-read the seam words
    send(1'b1, 6144, 12'hABC);
    send(1'b1, 7000, 12'h5A5);
    send(1'b1, 8191, 12'hFFF);
    for (int i = 0; i < 10; i++) send(1'b0, bnd[i], 12'h000);
    send(1'b0, 0, 12'h000);
    send(1'b0, 2048 + 1, 12'h000);

    // R5 out-of-range reads return zero
    send(1'b0, 6144, 12'h000);
    send(1'b0, 8191, 12'h000);
    send(1'b0, 6143, 12'h000);
    send(1'b0, 7000, 12'h000);

    // R6 explicit stall
    @(posedge clk); #1 rsp_ready = 1'b0;
    @(negedge clk);
    send(1'b0, 4096, 12'h000);
    for (int k = 0; k < 3; k++) begin
      chk(req_ready == 1'b0, "R6 req_ready low while stalled", {11'd0, req_ready}, 12'h000);
      chk(rsp_valid == 1'b1 && rsp_rdata == model[4096], "R6 response held", rsp_rdata, model[4096]);
      @(negedge clk);
    end
    @(posedge clk); #1 rsp_ready = 1'b1;
    @(negedge clk);
    send(1'b0, 2047, 12'h000);

    // mixed traffic under toggling back-pressure (R1 R6)
    toggle_en = 1'b1;
    for (int a = 100; a < WORDS; a += 211) begin
      send(1'b1, a, pat(a, 3));
      send(1'b0, a, 12'h000);
      send(1'b0, a ^ 12'h800, 12'h000);
    end
    for (int i = 0; i < 10; i++) send(1'b0, bnd[i], 12'h000);
    toggle_en = 1'b0;
    @(posedge clk); #1 rsp_ready = 1'b1;
    repeat (4) @(negedge clk);
    chk(exp_q.size() == 0, "R2 all reads answered", 12'(exp_q.size()), 12'h000);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule